// File: doc/BRIEF.md
# Prescaled Modulus Down-Counter with Capture Snapshot

This block is a 16-bit down-counter clocked through a selectable divider. Software writes a 16-bit load value and a small control register. The control register holds an enable bit, a mode bit that picks one-shot or auto-reload, a two-bit divider select and two write-one strobes. The first strobe transfers the load value into the count at once. The second strobe takes a snapshot of four external capture values and four on-chip 8-bit pulse accumulators into holding registers, and it clears the accumulators in the same cycle.

The divider select does not act on its own. The block samples it only when a load happens, either by the strobe or by an automatic reload. While the counter is off, the count is parked at all-ones. This keeps a stale zero from raising the flag at the moment the counter is turned on. The zero flag is a one-cycle pulse each time a decrement lands on zero.

Top module: `moddown_timer`

## Requirements
- R1: After reset, count is 16'hFFFF, zero_flag is low, ctrl_rdata is 0, and hold_cap, hold_acc and acc_now are all zero.
- R2: Control bits [3:2] select the division rate: 0 gives 1, 1 gives 4, 2 gives 8 and 3 gives 16. After a load, the count falls by one every N clocks, with the first decrement N clocks after the load edge.
- R3: A select written without a load leaves the active rate unchanged. The new rate takes effect at the next load. It also shows at once in ctrl_rdata[3:2].
- R4: While enable (bit 0) is clear, the count is 16'hFFFF. After the enable is set without a load, counting starts from 16'hFFFF at the active rate, and zero_flag stays low.
- R5: A control write with bit 4 set and bit 0 set copies the load register into the count at that edge and restarts the divider. This takes priority over a decrement due in the same cycle. With bit 0 clear in that write, bit 4 does nothing.
- R6: With mode bit 1 clear, the count stops at 16'h0000 and stays there.
- R7: With mode bit 1 set, the first divided tick after the count reaches zero reloads the load value and resamples the select. This gives a period of (load+1)*N clocks.
- R8: zero_flag is high for exactly the one cycle after a decrement takes the count from 1 to 0.
- R9: Control bits 4 and 5 always read back as zero. A control write with either of them clear does not perform that action.
- R10: A control write with bit 5 set while latch_mode and buf_en are both high does three things at that edge. It copies cap_in into hold_cap, copies the accumulators into hold_acc, and clears the accumulators.
- R11: A bit-5 write while latch_mode or buf_en is low leaves hold_cap, hold_acc and the accumulators unchanged.
- R12: Each accumulator counts the clocks on which its acc_pulse bit is high and wraps modulo 256. Channel i occupies bits [8i+7:8i] of acc_now and hold_acc, and bits [16i+15:16i] of cap_in and hold_cap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctrl_wr | input | 1 | Control register write strobe |
| ctrl_wdata | input | 6 | Control write data: enable, mode, select, force-load, latch |
| ctrl_rdata | output | 6 | Control readback (strobe bits always zero) |
| load_wr | input | 1 | Load register write strobe |
| load_wdata | input | 16 | Load register write data |
| latch_mode | input | 1 | Snapshot mode enable |
| buf_en | input | 1 | Holding-register buffering enable |
| cap_in | input | 64 | Four 16-bit capture values |
| acc_pulse | input | 4 | Per-channel accumulator increment |
| count | output | 16 | Current count |
| zero_flag | output | 1 | One-cycle pulse when the count reaches zero |
| hold_cap | output | 64 | Captured values held by the last snapshot |
| hold_acc | output | 32 | Accumulator values held by the last snapshot |
| acc_now | output | 32 | Live accumulator values |

## Verification
The hardest case to reach from the ports is a select change that must not take effect. A select that looks applied on the readback has to leave the divide ratio unchanged until a load occurs. The stimulus loads a long count at divide-by-1 and then rewrites the select to divide-by-16 with no load. It then checks that each following cycle still decrements by one before a later force-load switches the rate. Priority between a load and a tick is reached at divide-by-1, where a decrement is due on every edge, so a force-load lands on a cycle that would otherwise tick.

// File: rtl/moddown_pkg.sv
package moddown_pkg;
  localparam int CTRL_W = 6;
  localparam int B_EN   = 0;
  localparam int B_MODE = 1;
  localparam int B_PS   = 2;
  localparam int B_FL   = 4;
  localparam int B_LT   = 5;
  localparam int RAT_W  = 5;

  typedef struct packed {
    logic [1:0] ps;
    logic       reload;
    logic       en;
  } ctrl_t;

  // divider ratio for a select code
  function automatic logic [RAT_W-1:0] ps_ratio(input logic [1:0] sel);
    logic [RAT_W-1:0] r;
    case (sel)
      2'd0:    r = 5'd1;
      2'd1:    r = 5'd4;
      2'd2:    r = 5'd8;
      default: r = 5'd16;
    endcase
    return r;
  endfunction
endpackage

// File: rtl/mdt_prescaler.sv
module mdt_prescaler #(
  parameter int RAT_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             restart,
  input  logic [RAT_W-1:0] ratio,
  output logic             tick
);
  logic [RAT_W-1:0] pcnt;

  assign tick = run && (pcnt == ratio - RAT_W'(1));

  always_ff @(posedge clk) begin
    if (!rst_n)               pcnt <= '0;
    else if (restart || !run) pcnt <= '0;
    else if (tick)            pcnt <= '0;
    else                      pcnt <= pcnt + RAT_W'(1);
  end
endmodule

// File: rtl/mdt_count.sv
module mdt_count #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             reload_mode,
  input  logic             force_load,
  input  logic             tick,
  input  logic [CNT_W-1:0] load_val,
  input  logic [1:0]       sel_req,
  output logic [CNT_W-1:0] count,
  output logic [1:0]       act_sel,
  output logic             zero_flag,
  output logic             reload_evt
);
  function automatic logic [CNT_W-1:0] dec1(input logic [CNT_W-1:0] v);
    return v - CNT_W'(1);
  endfunction

  logic at_zero;
  assign at_zero    = (count == '0);
  assign reload_evt = !force_load && run && tick && at_zero && reload_mode;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count     <= '1;
      act_sel   <= 2'd0;
      zero_flag <= 1'b0;
    end else begin
      zero_flag <= 1'b0;
      if (force_load) begin
        count   <= load_val;
        act_sel <= sel_req;
      end else if (!run) begin
        count <= '1;
      end else if (tick) begin
        if (at_zero) begin
          if (reload_mode) begin
            count   <= load_val;
            act_sel <= sel_req;
          end
        end else begin
          count <= dec1(count);
          if (count == CNT_W'(1)) zero_flag <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/mdt_capture_hold.sv
module mdt_capture_hold #(
  parameter int CH    = 4,
  parameter int CAP_W = 16,
  parameter int ACC_W = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                latch,
  input  logic [CH*CAP_W-1:0] cap_in,
  input  logic [CH-1:0]       acc_pulse,
  output logic [CH*CAP_W-1:0] hold_cap,
  output logic [CH*ACC_W-1:0] hold_acc,
  output logic [CH*ACC_W-1:0] acc_now
);
  for (genvar i = 0; i < CH; i++) begin : g_ch
    logic [ACC_W-1:0] acc;
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        acc                          <= '0;
        hold_cap[i*CAP_W +: CAP_W]   <= '0;
        hold_acc[i*ACC_W +: ACC_W]   <= '0;
      end else if (latch) begin
        hold_cap[i*CAP_W +: CAP_W]   <= cap_in[i*CAP_W +: CAP_W];
        hold_acc[i*ACC_W +: ACC_W]   <= acc;
        acc                          <= '0;
      end else if (acc_pulse[i]) begin
        acc <= acc + ACC_W'(1);
      end
    end
    assign acc_now[i*ACC_W +: ACC_W] = acc;
  end
endmodule

// File: rtl/moddown_timer.sv
module moddown_timer
  import moddown_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int CH    = 4,
  parameter int CAP_W = 16,
  parameter int ACC_W = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                ctrl_wr,
  input  logic [CTRL_W-1:0]   ctrl_wdata,
  output logic [CTRL_W-1:0]   ctrl_rdata,
  input  logic                load_wr,
  input  logic [CNT_W-1:0]    load_wdata,
  input  logic                latch_mode,
  input  logic                buf_en,
  input  logic [CH*CAP_W-1:0] cap_in,
  input  logic [CH-1:0]       acc_pulse,
  output logic [CNT_W-1:0]    count,
  output logic                zero_flag,
  output logic [CH*CAP_W-1:0] hold_cap,
  output logic [CH*ACC_W-1:0] hold_acc,
  output logic [CH*ACC_W-1:0] acc_now
);
  ctrl_t            ctrl_q;
  logic [CNT_W-1:0] load_q;
  logic             force_load, latch_fire, tick, reload_evt;
  logic [1:0]       sel_req, act_sel;
  logic [RAT_W-1:0] ratio;

  assign force_load = ctrl_wr && ctrl_wdata[B_FL] && ctrl_wdata[B_EN];
  assign latch_fire = ctrl_wr && ctrl_wdata[B_LT] && latch_mode && buf_en;
  assign sel_req    = ctrl_wr ? ctrl_wdata[B_PS +: 2] : ctrl_q.ps;
  assign ratio      = ps_ratio(act_sel);
  assign ctrl_rdata = {2'b00, ctrl_q.ps, ctrl_q.reload, ctrl_q.en};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      load_q <= '0;
    end else begin
      if (ctrl_wr) begin
        ctrl_q.en     <= ctrl_wdata[B_EN];
        ctrl_q.reload <= ctrl_wdata[B_MODE];
        ctrl_q.ps     <= ctrl_wdata[B_PS +: 2];
      end
      if (load_wr) load_q <= load_wdata;
    end
  end

  mdt_prescaler #(.RAT_W(RAT_W)) u_ps (
    .clk(clk), .rst_n(rst_n), .run(ctrl_q.en), .restart(force_load),
    .ratio(ratio), .tick(tick)
  );

  mdt_count #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .run(ctrl_q.en), .reload_mode(ctrl_q.reload),
    .force_load(force_load), .tick(tick), .load_val(load_q), .sel_req(sel_req),
    .count(count), .act_sel(act_sel), .zero_flag(zero_flag), .reload_evt(reload_evt)
  );

  mdt_capture_hold #(.CH(CH), .CAP_W(CAP_W), .ACC_W(ACC_W)) u_cap (
    .clk(clk), .rst_n(rst_n), .latch(latch_fire), .cap_in(cap_in),
    .acc_pulse(acc_pulse), .hold_cap(hold_cap), .hold_acc(hold_acc), .acc_now(acc_now)
  );
endmodule

// File: rtl/moddown_timer_chk.sv
module moddown_timer_chk #(
  parameter int CNT_W = 16,
  parameter int HC_W  = 64,
  parameter int HA_W  = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             en_q,
  input logic             reload_q,
  input logic             force_load,
  input logic             latch_fire,
  input logic             tick,
  input logic             reload_evt,
  input logic [CNT_W-1:0] load_q,
  input logic [CNT_W-1:0] count,
  input logic             zero_flag,
  input logic [HC_W-1:0]  cap_in,
  input logic [HC_W-1:0]  hold_cap,
  input logic [HA_W-1:0]  hold_acc,
  input logic [HA_W-1:0]  acc_now
);
  assert_decrement_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q && tick && !force_load && count != '0) |=> count == CNT_W'($past(count) - 1));

  assert_disabled_preset_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_q && !force_load) |=> count == '1);

  assert_force_load_R5: assert property (@(posedge clk) disable iff (!rst_n)
    force_load |=> count == $past(load_q));

  assert_oneshot_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q && !reload_q && !force_load && count == '0) |=> count == '0);

  assert_reload_R7: assert property (@(posedge clk) disable iff (!rst_n)
    reload_evt |=> count == $past(load_q));

  assert_zero_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    zero_flag |-> (count == '0 && $past(count) == CNT_W'(1)));

  assert_latch_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
    latch_fire |=> (acc_now == '0 && hold_cap == $past(cap_in) && hold_acc == $past(acc_now)));

  assert_no_latch_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !latch_fire |=> ($stable(hold_cap) && $stable(hold_acc)));
endmodule

bind moddown_timer moddown_timer_chk #(
  .CNT_W(CNT_W), .HC_W(CH*CAP_W), .HA_W(CH*ACC_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .en_q(ctrl_q.en), .reload_q(ctrl_q.reload),
  .force_load(force_load), .latch_fire(latch_fire), .tick(tick),
  .reload_evt(reload_evt), .load_q(load_q), .count(count), .zero_flag(zero_flag),
  .cap_in(cap_in), .hold_cap(hold_cap), .hold_acc(hold_acc), .acc_now(acc_now)
);

// File: tb/sim_moddown_timer.sv
module sim_moddown_timer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ctrl_wr = 1'b0;
  logic [5:0]  ctrl_wdata = '0;
  logic [5:0]  ctrl_rdata;
  logic        load_wr = 1'b0;
  logic [15:0] load_wdata = '0;
  logic        latch_mode = 1'b0;
  logic        buf_en = 1'b0;
  logic [63:0] cap_in = '0;
  logic [3:0]  acc_pulse = '0;
  logic [15:0] count;
  logic        zero_flag;
  logic [63:0] hold_cap;
  logic [31:0] hold_acc;
  logic [31:0] acc_now;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  moddown_timer u0 (
    .clk(clk), .rst_n(rst_n), .ctrl_wr(ctrl_wr), .ctrl_wdata(ctrl_wdata),
    .ctrl_rdata(ctrl_rdata), .load_wr(load_wr), .load_wdata(load_wdata),
    .latch_mode(latch_mode), .buf_en(buf_en), .cap_in(cap_in), .acc_pulse(acc_pulse),
    .count(count), .zero_flag(zero_flag), .hold_cap(hold_cap), .hold_acc(hold_acc),
    .acc_now(acc_now)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic wr_ctrl(input logic [5:0] d);
    @(negedge clk); ctrl_wr = 1'b1; ctrl_wdata = d;
    @(negedge clk); ctrl_wr = 1'b0; ctrl_wdata = '0;
  endtask

  task automatic wr_load(input logic [15:0] d);
    @(negedge clk); load_wr = 1'b1; load_wdata = d;
    @(negedge clk); load_wr = 1'b0;
  endtask

  function automatic int ratio_of(input int sel);
    return (sel == 0) ? 1 : (2 << sel);
  endfunction

  initial begin
    #(4 * 150000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: run did not complete");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [15:0] prev;
    logic [31:0] exp_acc;
    logic [63:0] cap_a, cap_b;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 count", count, 16'hFFFF);
    check("R1 zero_flag", zero_flag, 0);
    check("R1 rdata", ctrl_rdata, 0);
    check("R1 hold_cap", hold_cap, 0);
    check("R1 hold_acc", hold_acc, 0);
    check("R1 acc_now", acc_now, 0);

    // R2 R5 R6 R8: one-shot sweep over every select
    for (int sel = 0; sel < 4; sel++) begin
      int n;
      int l;
      n = ratio_of(sel);
      l = 5;
      wr_load(16'(l));
      wr_ctrl(6'(1 | (sel << 2) | (1 << 4)));
      for (int c = 0; c < (l + 2) * n + 3; c++) begin
        int e;
        e = (c / n >= l) ? 0 : l - c / n;
        check("R2 R6 count", count, 64'(e));
        check("R8 zero_flag", zero_flag, 64'(c == l * n));
        @(negedge clk);
      end
    end

    // R5: force-load wins over a tick at divide-by-1
    wr_load(16'd200);
    wr_ctrl(6'b01_0001);
    check("R5 load beats tick", count, 200);
    repeat (3) @(negedge clk);
    wr_ctrl(6'b01_0001);
    check("R5 reload mid-count", count, 200);

    // R3 R9: select change without load keeps rate
    wr_ctrl(6'b00_1101);
    check("R9 strobe readback", ctrl_rdata[5:4], 0);
    check("R3 select readback", ctrl_rdata[3:2], 3);
    for (int c = 0; c < 10; c++) begin
      prev = count;
      @(negedge clk);
      check("R3 rate unchanged", count, 64'(prev - 16'd1));
    end
    wr_ctrl(6'b01_1101);
    for (int c = 0; c < 34; c++) begin
      check("R3 new rate after load", count, 64'(200 - c / 16));
      @(negedge clk);
    end

    // R7 R8: reload mode, L=3, divide-by-4
    wr_load(16'd3);
    wr_ctrl(6'b01_0111);
    for (int c = 0; c < 48; c++) begin
      int ph;
      ph = c % 16;
      check("R7 reload count", count, 64'(3 - ph / 4));
      check("R8 reload zero_flag", zero_flag, 64'(ph == 12));
      @(negedge clk);
    end

    // R4 R5: disable, force-load ignored while off, re-enable
    wr_ctrl(6'b00_0100);
    @(negedge clk);
    check("R4 disabled preset", count, 16'hFFFF);
    wr_ctrl(6'b01_0000);
    @(negedge clk);
    check("R5 load ignored when off", count, 16'hFFFF);
    wr_ctrl(6'b00_0101);
    for (int c = 0; c < 9; c++) begin
      check("R4 count from all-ones", count, 64'(16'hFFFF - 16'(c / 4)));
      check("R4 no early flag", zero_flag, 0);
      @(negedge clk);
    end

    // R12 R10: accumulate then snapshot
    cap_a = 64'h1111_2222_3333_4444;
    cap_b = 64'hAAAA_BBBB_CCCC_DDDD;
    cap_in = cap_a;
    for (int p = 0; p < 6; p++) begin
      for (int i = 0; i < 4; i++) acc_pulse[i] = (p < i + 2);
      @(negedge clk);
    end
    acc_pulse = '0;
    exp_acc = {8'd5, 8'd4, 8'd3, 8'd2};
    check("R12 accumulators", acc_now, 64'(exp_acc));
    latch_mode = 1'b1; buf_en = 1'b1;
    wr_ctrl(6'b10_0101);
    check("R10 hold_cap", hold_cap, cap_a);
    check("R10 hold_acc", hold_acc, 64'(exp_acc));
    check("R10 acc cleared", acc_now, 0);
    check("R9 latch bit reads zero", ctrl_rdata[5:4], 0);

    // R11: latch blocked by either enable
    for (int p = 0; p < 3; p++) begin
      acc_pulse = 4'hF; @(negedge clk);
    end
    acc_pulse = '0;
    cap_in = cap_b;
    latch_mode = 1'b0; buf_en = 1'b1;
    wr_ctrl(6'b10_0101);
    check("R11 mode off hold_cap", hold_cap, cap_a);
    check("R11 mode off hold_acc", hold_acc, 64'(exp_acc));
    check("R11 mode off acc kept", acc_now, 32'h0303_0303);
    latch_mode = 1'b1; buf_en = 1'b0;
    wr_ctrl(6'b10_0101);
    check("R11 buf off hold_cap", hold_cap, cap_a);
    check("R11 buf off acc kept", acc_now, 32'h0303_0303);
    buf_en = 1'b1;
    wr_ctrl(6'b00_0101);
    check("R9 zero latch bit no effect", hold_cap, cap_a);
    check("R9 zero latch bit acc kept", acc_now, 32'h0303_0303);
    wr_ctrl(6'b10_0101);
    check("R10 second snapshot cap", hold_cap, cap_b);
    check("R10 second snapshot acc", hold_acc, 32'h0303_0303);

    // R12: wrap modulo 256 on channel 0
    acc_pulse = 4'b0001;
    repeat (258) @(negedge clk);
    acc_pulse = '0;
    check("R12 wrap", acc_now, 32'h0000_0002);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule